// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregation Controller

This block gathers a word of level-sensitive interrupt request lines and presents them to a processor as two interrupt outputs. Each request line first passes through a two-stage synchroniser. A per-line enable mask selects which lines may take part. A per-line route bit steers each line to one of the two outputs. One bit of the enable mask acts as a master switch for the whole block.

Software reaches the block through a simple single-cycle register port. The enable mask is never written directly. One register sets mask bits and another clears them, so several agents can change individual lines without a read-modify-write. Software acknowledges a line by masking it, which drops the line from the pending view on the very next clock. Nothing is latched: a line is pending for exactly as long as its synchronised input is high and it is enabled.

Register offsets (byte addresses on `bus_addr`): pending word for output 0 at 0x00, pending word for output 1 at 0x04, route word at 0x20, synchronised-level word at 0x30, mask-set at 0x34, mask-clear at 0x38.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable mask and the route word are all zero, both interrupt outputs are low, and both pending words read 0.
- R2: Writing to offset 0x34 sets every enable bit whose data bit is 1 and leaves the others unchanged. A read at 0x34 returns the current enable mask, and so does a read at 0x38.
- R3: Writing to offset 0x38 clears every enable bit whose data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears the whole mask.
- R4: Enable bit 31 is the master switch. While it is 0, both outputs are low and both pending words read 0, whatever the other bits are.
- R5: With route bit i = 0, line i can appear only in the pending word at 0x00 and drive output 0. With route bit i = 1, it can appear only in the pending word at 0x04 and drive output 1. The route word reads back at 0x20.
- R6: Pending bit i is the synchronised line i AND enable bit i AND the selected route AND enable bit 31. A pending bit clears once its input has been low through two clock edges, so nothing is latched.
- R7: A clear write that covers an active line removes that line from its pending word, and from its output, right after the clock edge that accepts the write.
- R8: Offset 0x30 returns the request lines as they stood two clock edges earlier, regardless of the mask.
- R9: A read at any offset other than the six listed returns 0.
- R10: Each output is high exactly when its pending word is non-zero.
- R11: A write takes effect only when `bus_sel` and `bus_we` are both high at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Asynchronous level-sensitive request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| cpu_irq0 | output | 1 | Interrupt output 0 |
| cpu_irq1 | output | 1 | Interrupt output 1 |

## Verification
The assertions assume that a write is presented as a single strobe of one cycle, with address and data stable at the accepting edge. They also assume that request lines change only between clock edges after the synchroniser, so the pending words are compared only against the synchronised levels. The bench drives every bus field and every request line at the falling edge. It holds each write for exactly one rising edge and lets at least two edges pass after changing a request line before it samples a pending word or an output.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int NSRC      = 32;
    localparam int ADDR_W    = 8;
    localparam int MASTER_IX = 31;

    localparam logic [7:0] OFS_PEND0  = 8'h00;
    localparam logic [7:0] OFS_PEND1  = 8'h04;
    localparam logic [7:0] OFS_ROUTE  = 8'h20;
    localparam logic [7:0] OFS_LEVEL  = 8'h30;
    localparam logic [7:0] OFS_MSET   = 8'h34;
    localparam logic [7:0] OFS_MCLR   = 8'h38;

    localparam int NCHAN = 2;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/irqagg_route.sv
module irqagg_route #(
    parameter int W         = 32,
    parameter int MASTER_IX = 31,
    parameter int NCHAN     = 2
) (
    input  logic             [W-1:0] level,
    input  logic             [W-1:0] en_mask,
    input  logic             [W-1:0] route_mask,
    output logic [NCHAN-1:0] [W-1:0] pend,
    output logic [NCHAN-1:0]         irq_out
);

    logic [W-1:0] gated;

    // master switch gates every line before routing
    assign gated = level & en_mask & {W{en_mask[MASTER_IX]}};

    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
        logic [W-1:0] pick;
        if (ch == 0) begin : g_lo
            assign pick = ~route_mask;
        end else begin : g_hi
            assign pick = route_mask;
        end
        assign pend[ch]    = gated & pick;
        assign irq_out[ch] = |pend[ch];
    end

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  level,
    input  logic [W-1:0]  pend0,
    input  logic [W-1:0]  pend1,
    output logic [W-1:0]  en_mask,
    output logic [W-1:0]  route_mask,
    output logic [W-1:0]  rdata
);

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sel && we) begin
            case (addr)
                AW'(OFS_MSET):  cfg_d.en    = cfg_q.en | wdata;
                AW'(OFS_MCLR):  cfg_d.en    = cfg_q.en & ~wdata;
                AW'(OFS_ROUTE): cfg_d.route = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !we) begin
            case (addr)
                AW'(OFS_PEND0): rdata = pend0;
                AW'(OFS_PEND1): rdata = pend1;
                AW'(OFS_ROUTE): rdata = cfg_q.route;
                AW'(OFS_LEVEL): rdata = level;
                AW'(OFS_MSET):  rdata = cfg_q.en;
                AW'(OFS_MCLR):  rdata = cfg_q.en;
                default:        rdata = '0;
            endcase
        end
    end

    assign en_mask    = cfg_q.en;
    assign route_mask = cfg_q.route;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              cpu_irq0,
    output logic              cpu_irq1
);

    logic [NSRC-1:0]              level;
    logic [NSRC-1:0]              en_mask;
    logic [NSRC-1:0]              route_mask;
    logic [NCHAN-1:0][NSRC-1:0]   pend;
    logic [NCHAN-1:0]             irq_out;

    irqagg_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .dout  (level)
    );

    irqagg_regs #(.W(NSRC), .AW(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .level      (level),
        .pend0      (pend[0]),
        .pend1      (pend[1]),
        .en_mask    (en_mask),
        .route_mask (route_mask),
        .rdata      (bus_rdata)
    );

    irqagg_route #(.W(NSRC), .MASTER_IX(MASTER_IX), .NCHAN(NCHAN)) u_route (
        .level      (level),
        .en_mask    (en_mask),
        .route_mask (route_mask),
        .pend       (pend),
        .irq_out    (irq_out)
    );

    assign cpu_irq0 = irq_out[0];
    assign cpu_irq1 = irq_out[1];

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic [NSRC-1:0]   en_mask,
    input logic [NSRC-1:0]   level,
    input logic [NSRC-1:0]   pend0,
    input logic [NSRC-1:0]   pend1,
    input logic              cpu_irq0,
    input logic              cpu_irq1
);

    logic set_wr, clr_wr;
    assign set_wr = bus_sel && bus_we && (bus_addr == OFS_MSET);
    assign clr_wr = bus_sel && bus_we && (bus_addr == OFS_MCLR);

    assert_mask_zero_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_mask == '0));

    assert_set_takes_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en_mask & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_drops_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((en_mask & $past(bus_wdata)) == '0));

    assert_master_off_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mask[MASTER_IX] |-> (!cpu_irq0 && !cpu_irq1));

    assert_routes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend0 & pend1) == '0);

    assert_pending_needs_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend0 | pend1) & ~level) == '0);

    assert_ack_removes_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (((pend0 | pend1) & $past(bus_wdata)) == '0));

endmodule

bind irq_aggregator irqagg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_mask   (en_mask),
    .level     (level),
    .pend0     (pend[0]),
    .pend1     (pend[1]),
    .cpu_irq0  (cpu_irq0),
    .cpu_irq1  (cpu_irq1)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq0, cpu_irq1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1)
    );

    typedef struct packed {
        logic [31:0] lines;
        logic [31:0] mask;
        logic [31:0] route;
        logic [31:0] exp_p0;
        logic [31:0] exp_p1;
        logic        exp_o0;
        logic        exp_o1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_00FF, 32'h8000_000F, 32'h0000_0000, 32'h0000_000F, 32'h0000_0000, 1'b1, 1'b0},
        '{32'h0000_00FF, 32'h8000_00FF, 32'h0000_00F0, 32'h0000_000F, 32'h0000_00F0, 1'b1, 1'b1},
        '{32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{32'hFFFF_0000, 32'h8001_0100, 32'h0001_0000, 32'h8000_0000, 32'h0001_0000, 1'b1, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5, 1'b0, 1'b1},
        '{32'h1234_5678, 32'h8000_FFFF, 32'h0000_FF00, 32'h0000_0078, 32'h0000_5600, 1'b1, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h34, r); check("R1 mask", r, 32'h0);
        rd(8'h20, r); check("R1 route", r, 32'h0);
        rd(8'h00, r); check("R1 pend0", r, 32'h0);
        rd(8'h04, r); check("R1 pend1", r, 32'h0);
        check("R1 outputs", {30'b0, cpu_irq1, cpu_irq0}, 32'h0);

        // table walk: R5 R6 R10 R4 R8
        for (int i = 0; i < NV; i++) begin
            wr(8'h38, 32'hFFFF_FFFF);
            wr(8'h34, VEC[i].mask);
            wr(8'h20, VEC[i].route);
            irq_in = VEC[i].lines;
            settle();
            rd(8'h00, r); check("R5/R6 pend0", r, VEC[i].exp_p0);
            rd(8'h04, r); check("R5/R6 pend1", r, VEC[i].exp_p1);
            check("R10 outputs", {30'b0, cpu_irq1, cpu_irq0},
                  {30'b0, VEC[i].exp_o1, VEC[i].exp_o0});
            rd(8'h30, r); check("R8 level", r, VEC[i].lines);
            rd(8'h20, r); check("R5 route readback", r, VEC[i].route);
        end

        // R2 set leaves zeros alone; both offsets read back
        irq_in = '0;
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h20, 32'h0);
        wr(8'h34, 32'h0000_0001);
        wr(8'h34, 32'h0000_0002);
        rd(8'h34, r); check("R2 set accumulates", r, 32'h0000_0003);
        rd(8'h38, r); check("R2 read at clear offset", r, 32'h0000_0003);

        // R3 clear selected, then clear all
        wr(8'h38, 32'h0000_0001);
        rd(8'h34, r); check("R3 clear one", r, 32'h0000_0002);
        wr(8'h34, 32'hF0F0_0000);
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h34, r); check("R3 clear all", r, 32'h0);

        // R11 writes without select or write-enable are ignored
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 8'h34; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        rd(8'h34, r); check("R11 no stray write", r, 32'h0);

        // R7 acknowledge by masking, effective right after the accepting edge
        wr(8'h34, 32'h8000_0001);
        irq_in = 32'h0000_0001;
        settle();
        check("R7 active before ack", {31'b0, cpu_irq0}, 32'h1);
        wr(8'h38, 32'h0000_0001);
        check("R7 output after ack", {31'b0, cpu_irq0}, 32'h0);
        rd(8'h00, r); check("R7 pend after ack", r, 32'h0);

        // R6 no latching: level drop clears after two edges
        wr(8'h34, 32'h0000_0001);
        settle();
        check("R6 pending again", {31'b0, cpu_irq0}, 32'h1);
        irq_in = '0;
        @(negedge clk);
        check("R6 still one edge", {31'b0, cpu_irq0}, 32'h1);
        @(negedge clk);
        check("R6 cleared after two edges", {31'b0, cpu_irq0}, 32'h0);

        // R8 two-edge latency on the level view, mask ignored
        wr(8'h38, 32'hFFFF_FFFF);
        irq_in = 32'h5A5A_0F0F;
        @(negedge clk);
        rd(8'h30, r); check("R8 one edge old", r, 32'h0);
        @(negedge clk);
        rd(8'h30, r); check("R8 two edges new", r, 32'h5A5A_0F0F);

        // R4 master bit clear with line enabled
        wr(8'h34, 32'h0000_0F0F);
        settle();
        rd(8'h00, r); check("R4 pend0 master off", r, 32'h0);
        check("R4 outputs master off", {30'b0, cpu_irq1, cpu_irq0}, 32'h0);

        // R9 unmapped offsets
        wr(8'h34, 32'h8000_0000);
        rd(8'h08, r); check("R9 offset 08", r, 32'h0);
        rd(8'h3C, r); check("R9 offset 3C", r, 32'h0);
        rd(8'h35, r); check("R9 offset 35", r, 32'h0);
        rd(8'hFF, r); check("R9 offset FF", r, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule